// File: doc/BRIEF.md
# Time-Multiplexed Resonator Oscillator Bank

This block produces the sum of many sinusoidal partials. Each partial is a marginally stable two-state recursion. It runs on a single shared multiplier and subtractor that visits the partials one per clock in fixed index order. The two state words and the frequency word of every partial sit in a bank of registers. The oscillator tap of each partial is rounded to 16 bits and scaled by two separate amplitude envelopes, one for each output channel. The scaled taps are summed into a left mix and a right mix, and both mixes are presented at the end of every sample.

Synthesis runs in frames. A pulse on the start input begins a frame of a fixed number of samples. Once the frame ends, the block opens an update window and waits. While that window is open, a host can write any state, frequency or envelope word of any partial through the load port. Writes that arrive while a frame is running are dropped, so every sample of a frame uses one consistent set of parameters. The state words are not reloaded at a frame edge unless the host writes them, so the oscillators carry on without a break from one frame to the next.

Top module: `partial_osc_bank`

## Requirements
- R1: For each partial on each sample, the next x0 is the old x1. The next x1 is ((w*x1) arithmetically shifted right by 22) minus the old x0, wrapped to 24-bit two's complement. w is signed with 22 fraction bits, and x0 and x1 are signed with 23 fraction bits.
- R2: The tap of a partial is its current x1 rounded to 16 bits as (x1 + 128) arithmetically shifted right by 8. A result above 32767 saturates to 32767.
- R3: An envelope word holds an unsigned 16-bit amplitude in bits 23:8 and a signed 8-bit slope in bits 7:0. A sample uses the current amplitude. After that sample the amplitude becomes amplitude + slope, clamped to the range 0 to 65535.
- R4: The contribution of a partial to a channel is floor(tap * amplitude / 4096), using that channel's own envelope. The left and right envelopes are independent.
- R5: Each channel's output is the sum of the contributions of all partials for one sample, saturated to the signed 20-bit range. It updates together with a one-cycle sample_valid pulse, the pulses of one frame are exactly N_PARTIALS cycles apart, and the output holds between pulses.
- R6: Load field codes are 0 = x0, 1 = x1, 2 = w, 3 = left envelope and 4 = right envelope. A write is applied only while load_ready is high. Writes made while a frame runs, writes with other codes and writes with an out-of-range index are ignored.
- R7: A frame_go pulse accepted while load_ready is high drops load_ready on the next cycle. The frame then yields exactly FRAME_LEN samples, and load_ready rises in the cycle of the last sample_valid and stays high until the next frame_go. A frame_go pulse during a frame is ignored.
- R8: After reset, load_ready is 1, sample_valid is 0 and both mixes are 0.
- R9: The state and envelopes carry over between frames. A frame that starts without any reload continues the recursion and ramps from where the previous frame stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parameter write strobe |
| load_sel | input | 3 | Field code of the write |
| load_idx | input | IDX_W | Partial index of the write |
| load_data | input | 24 | Value written |
| frame_go | input | 1 | Start a frame |
| load_ready | output | 1 | Update window open |
| sample_valid | output | 1 | New mix sample present |
| mix_l | output | 20 | Left channel mix, signed |
| mix_r | output | 20 | Right channel mix, signed |

## Verification
If one partial's state word goes wrong, the error is visible in the very next sample of both channels. It then grows or rotates with the recursion in every later sample, so a comparison sample by sample against an exact recursion finds it within one sample period. An envelope that wraps instead of clamping gives a step of roughly full scale, and it shows within a few samples of the clamp point. A sequencer fault moves the sample_valid pulses, changes how many samples a frame has, or leaves the update window open while a frame runs. Any of these is caught in the first frame by counting cycles and pulses.

// File: rtl/osc_pkg.sv
package osc_pkg;

    localparam int XW         = 24;
    localparam int W_FRAC     = 22;
    localparam int TAP_W      = 16;
    localparam int AMP_W      = 16;
    localparam int SLOPE_W    = 8;
    localparam int OUT_W      = 20;
    localparam int TERM_SHIFT = 12;
    localparam int N_CH       = 2;

    typedef logic signed [XW-1:0] word_t;
    typedef logic signed [TAP_W-1:0] tap_t;
    typedef logic signed [OUT_W-1:0] mix_t;

    typedef struct packed {
        logic [AMP_W-1:0]          amp;
        logic signed [SLOPE_W-1:0] slope;
    } env_t;

    typedef struct packed {
        word_t x0;
        word_t x1;
        word_t w;
        env_t  env_l;
        env_t  env_r;
    } partial_t;

    typedef enum logic [2:0] {
        FLD_X0    = 3'd0,
        FLD_X1    = 3'd1,
        FLD_W     = 3'd2,
        FLD_ENV_L = 3'd3,
        FLD_ENV_R = 3'd4
    } field_e;

    typedef enum logic {
        PH_UPDATE = 1'b0,
        PH_RUN    = 1'b1
    } phase_e;

    // amplitude plus signed slope, clamped to the unsigned amplitude range
    function automatic env_t env_step(input env_t e);
        logic signed [AMP_W+1:0] s;
        env_t r;
        s = $signed({2'b00, e.amp}) + $signed({{(AMP_W+2-SLOPE_W){e.slope[SLOPE_W-1]}}, e.slope});
        r.slope = e.slope;
        if (s[AMP_W+1])
            r.amp = '0;
        else if (s[AMP_W])
            r.amp = '1;
        else
            r.amp = s[AMP_W-1:0];
        return r;
    endfunction

    // round a state word to the tap width, saturating the top end
    function automatic tap_t round_tap(input word_t x);
        logic signed [XW:0]    s;
        logic signed [TAP_W:0] q;
        s = {x[XW-1], x} + (XW+1)'(128);
        q = s[XW:XW-TAP_W];
        if (q > (TAP_W+1)'(32767))
            return tap_t'(16'sh7FFF);
        return q[TAP_W-1:0];
    endfunction

endpackage

// File: rtl/resonator_step.sv
module resonator_step
    import osc_pkg::*;
(
    input  partial_t cur,
    output word_t    nx0,
    output word_t    nx1,
    output tap_t     tap
);
    logic signed [2*XW-1:0] prod;
    logic signed [2*XW-1:0] scaled;

    assign prod   = cur.w * cur.x1;
    assign scaled = prod >>> W_FRAC;
    assign nx0    = cur.x1;
    assign nx1    = scaled[XW-1:0] - cur.x0;
    assign tap    = round_tap(cur.x1);
endmodule

// File: rtl/env_scale.sv
module env_scale
    import osc_pkg::*;
(
    input  tap_t tap,
    input  env_t env,
    output mix_t term,
    output env_t env_nxt
);
    localparam int P_W = TAP_W + AMP_W + 2;

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] shifted;

    assign prod    = $signed(tap) * $signed({1'b0, env.amp});
    assign shifted = prod >>> TERM_SHIFT;
    assign term    = shifted[OUT_W-1:0];
    assign env_nxt = env_step(env);
endmodule

// File: rtl/mix_accum.sv
module mix_accum
    import osc_pkg::*;
#(
    parameter int N_PARTIALS = 1200
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic last,
    input  mix_t term,
    output mix_t mix
);
    localparam int GUARD = $clog2(N_PARTIALS) + 1;
    localparam int ACC_W = OUT_W + GUARD;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum;
    logic [GUARD:0]          top_bits;
    mix_t                    sat;

    assign sum      = acc + {{GUARD{term[OUT_W-1]}}, term};
    assign top_bits = sum[ACC_W-1:OUT_W-1];

    always_comb begin
        if (top_bits == '0 || top_bits == '1)
            sat = sum[OUT_W-1:0];
        else if (sum[ACC_W-1])
            sat = {1'b1, {(OUT_W-1){1'b0}}};
        else
            sat = {1'b0, {(OUT_W-1){1'b1}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            mix <= '0;
        end else if (en) begin
            if (last) begin
                acc <= '0;
                mix <= sat;
            end else begin
                acc <= sum;
            end
        end
    end
endmodule

// File: rtl/partial_osc_bank.sv
module partial_osc_bank
    import osc_pkg::*;
#(
    parameter int N_PARTIALS = 1200,
    parameter int FRAME_LEN  = 128,
    localparam int IDX_W = (N_PARTIALS > 1) ? $clog2(N_PARTIALS) : 1,
    localparam int SC_W  = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [2:0]       load_sel,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [XW-1:0]    load_data,
    input  logic             frame_go,
    output logic             load_ready,
    output logic             sample_valid,
    output logic [OUT_W-1:0] mix_l,
    output logic [OUT_W-1:0] mix_r
);
    partial_t bank [N_PARTIALS];

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [SC_W-1:0]  scnt;
    logic             run;
    logic             last_p;
    logic             last_s;

    partial_t cur;
    word_t    nx0;
    word_t    nx1;
    tap_t     tap;
    env_t     env_cur [N_CH];
    env_t     env_nxt [N_CH];
    mix_t     term    [N_CH];
    mix_t     mix_q   [N_CH];

    assign run        = (phase == PH_RUN);
    assign last_p     = (idx == IDX_W'(N_PARTIALS - 1));
    assign last_s     = (scnt == SC_W'(FRAME_LEN - 1));
    assign load_ready = (phase == PH_UPDATE);
    assign cur        = bank[idx];
    assign env_cur[0] = cur.env_l;
    assign env_cur[1] = cur.env_r;

    resonator_step u_step (
        .cur (cur),
        .nx0 (nx0),
        .nx1 (nx1),
        .tap (tap)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        env_scale u_scale (
            .tap     (tap),
            .env     (env_cur[ch]),
            .term    (term[ch]),
            .env_nxt (env_nxt[ch])
        );
        mix_accum #(.N_PARTIALS(N_PARTIALS)) u_acc (
            .clk  (clk),
            .rst  (rst),
            .en   (run),
            .last (last_p),
            .term (term[ch]),
            .mix  (mix_q[ch])
        );
    end

    assign mix_l = mix_q[0];
    assign mix_r = mix_q[1];

    // register bank: recursion write-back while running, host writes otherwise
    always_ff @(posedge clk) begin
        if (run) begin
            bank[idx] <= '{x0: nx0, x1: nx1, w: cur.w,
                           env_l: env_nxt[0], env_r: env_nxt[1]};
        end else if (load_en && (32'(load_idx) < N_PARTIALS)) begin
            case (field_e'(load_sel))
                FLD_X0:    bank[load_idx].x0    <= load_data;
                FLD_X1:    bank[load_idx].x1    <= load_data;
                FLD_W:     bank[load_idx].w     <= load_data;
                FLD_ENV_L: bank[load_idx].env_l <= load_data;
                FLD_ENV_R: bank[load_idx].env_r <= load_data;
                default:   ;
            endcase
        end
    end

    // frame sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_UPDATE;
            idx          <= '0;
            scnt         <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= run && last_p;
            case (phase)
                PH_UPDATE: begin
                    if (frame_go) begin
                        phase <= PH_RUN;
                        idx   <= '0;
                        scnt  <= '0;
                    end
                end
                PH_RUN: begin
                    if (last_p) begin
                        idx <= '0;
                        if (last_s)
                            phase <= PH_UPDATE;
                        else
                            scnt <= scnt + 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: phase <= PH_UPDATE;
            endcase
        end
    end
endmodule

// File: rtl/osc_bank_checker.sv
module osc_bank_checker #(
    parameter int N_PARTIALS = 1200,
    parameter int FRAME_LEN  = 128
) (
    input logic        clk,
    input logic        rst,
    input logic        frame_go,
    input logic        load_ready,
    input logic        sample_valid,
    input logic [19:0] mix_l,
    input logic [19:0] mix_r
);
    int   frame_cnt;
    int   gap;
    logic have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= 0;
            gap       <= 0;
            have_prev <= 1'b0;
        end else begin
            if (load_ready && frame_go) begin
                frame_cnt <= 0;
                have_prev <= 1'b0;
            end else if (sample_valid) begin
                frame_cnt <= frame_cnt + 1;
                have_prev <= 1'b1;
            end
            gap <= sample_valid ? 0 : gap + 1;
        end
    end

    AST_GO_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (rst)
        load_ready && frame_go |=> !load_ready); // R7

    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        load_ready && !frame_go |=> load_ready); // R7

    AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> frame_cnt < FRAME_LEN); // R7

    AST_READY_AT_END: assert property (@(posedge clk) disable iff (rst)
        sample_valid && frame_cnt == FRAME_LEN - 1 |-> load_ready); // R7

    AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (rst)
        sample_valid && have_prev && !load_ready |-> gap == N_PARTIALS - 1); // R5

    AST_MIX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> $stable(mix_l) && $stable(mix_r)); // R5
endmodule

bind partial_osc_bank osc_bank_checker #(
    .N_PARTIALS (N_PARTIALS),
    .FRAME_LEN  (FRAME_LEN)
) u_osc_bank_checker (
    .clk          (clk),
    .rst          (rst),
    .frame_go     (frame_go),
    .load_ready   (load_ready),
    .sample_valid (sample_valid),
    .mix_l        (mix_l),
    .mix_r        (mix_r)
);

// File: tb/partial_osc_bank_bench.sv
`timescale 1ns/1ps
module partial_osc_bank_bench;
    localparam int NP    = 3;
    localparam int FL    = 4;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             load_en = 1'b0;
    logic [2:0]       load_sel = '0;
    logic [IDX_W-1:0] load_idx = '0;
    logic [23:0]      load_data = '0;
    logic             frame_go = 1'b0;
    logic             load_ready;
    logic             sample_valid;
    logic [19:0]      mix_l;
    logic [19:0]      mix_r;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    longint m_x0 [NP];
    longint m_x1 [NP];
    longint m_w  [NP];
    longint m_al [NP];
    longint m_dl [NP];
    longint m_ar [NP];
    longint m_dr [NP];
    bit     exp_ready = 1'b1;
    longint first_l, first_r;

    partial_osc_bank #(.N_PARTIALS(NP), .FRAME_LEN(FL)) u_partial_osc_bank (
        .clk          (clk),
        .rst          (rst),
        .load_en      (load_en),
        .load_sel     (load_sel),
        .load_idx     (load_idx),
        .load_data    (load_data),
        .frame_go     (frame_go),
        .load_ready   (load_ready),
        .sample_valid (sample_valid),
        .mix_l        (mix_l),
        .mix_r        (mix_r)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint wrap24(input longint v);
        longint r;
        r = v & 64'hFFFFFF;
        if (r >= 64'sd8388608) r = r - 64'sd16777216;
        return r;
    endfunction

    function automatic longint rnd16(input longint x);
        longint r;
        r = (x + 128) >>> 8;
        if (r > 32767) r = 32767;
        return r;
    endfunction

    function automatic longint clamp_amp(input longint a);
        if (a < 0) return 0;
        if (a > 65535) return 65535;
        return a;
    endfunction

    function automatic longint sat20(input longint v);
        if (v > 524287) return 524287;
        if (v < -524288) return -524288;
        return v;
    endfunction

    function automatic longint sx20(input logic [19:0] v);
        return longint'($signed(v));
    endfunction

    // drive one write; the model follows only when the window is expected open
    task automatic load_word(input int sel, input int idx, input longint data);
        @(negedge clk);
        load_en   = 1'b1;
        load_sel  = 3'(sel);
        load_idx  = IDX_W'(idx);
        load_data = 24'(data);
        @(negedge clk);
        load_en = 1'b0;
        if (exp_ready && idx < NP) begin
            case (sel)
                0: m_x0[idx] = wrap24(data);
                1: m_x1[idx] = wrap24(data);
                2: m_w[idx]  = wrap24(data);
                3: begin
                    m_al[idx] = (data >>> 8) & 64'hFFFF;
                    m_dl[idx] = data & 64'hFF;
                    if (m_dl[idx] >= 128) m_dl[idx] = m_dl[idx] - 256;
                end
                4: begin
                    m_ar[idx] = (data >>> 8) & 64'hFFFF;
                    m_dr[idx] = data & 64'hFF;
                    if (m_dr[idx] >= 128) m_dr[idx] = m_dr[idx] - 256;
                end
                default: ;
            endcase
        end
    endtask

    // one reference sample, then advance the reference state
    task automatic model_sample(output longint el, output longint er);
        longint sl, sr, t, nx;
        sl = 0;
        sr = 0;
        for (int p = 0; p < NP; p++) begin
            t  = rnd16(m_x1[p]);
            sl = sl + ((t * m_al[p]) >>> 12);
            sr = sr + ((t * m_ar[p]) >>> 12);
        end
        el = sat20(sl);
        er = sat20(sr);
        for (int p = 0; p < NP; p++) begin
            nx      = wrap24(((m_w[p] * m_x1[p]) >>> 22) - m_x0[p]);
            m_x0[p] = m_x1[p];
            m_x1[p] = nx;
            m_al[p] = clamp_amp(m_al[p] + m_dl[p]);
            m_ar[p] = clamp_amp(m_ar[p] + m_dr[p]);
        end
    endtask

    task automatic run_frame(input bit inject, input string tag);
        int     cyc;
        bit     inj_done;
        bit     stray;
        longint el, er;
        inj_done = 1'b0;
        @(negedge clk);
        frame_go = 1'b1;
        @(negedge clk);
        frame_go  = 1'b0;
        exp_ready = 1'b0;
        cyc = 1;
        for (int s = 0; s < FL; s++) begin
            while (sample_valid !== 1'b1) begin
                if (inject && s == 1 && !inj_done) begin
                    // R6 write while running, R7 start while running: both ignored
                    load_en   = 1'b1;
                    load_sel  = 3'd1;
                    load_idx  = '0;
                    load_data = 24'h123456;
                    frame_go  = 1'b1;
                    inj_done  = 1'b1;
                end else begin
                    load_en  = 1'b0;
                    frame_go = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
            chk(cyc == ((s == 0) ? NP + 1 : NP), "R5", {tag, " sample spacing"},
                cyc, (s == 0) ? NP + 1 : NP);
            chk(load_ready == (s == FL - 1), "R7", {tag, " window during frame"},
                load_ready, (s == FL - 1));
            model_sample(el, er);
            if (s == 0) begin
                first_l = sx20(mix_l);
                first_r = sx20(mix_r);
            end
            chk(sx20(mix_l) == el, "R1 R2 R3 R4 R5", {tag, " left mix"}, sx20(mix_l), el);
            chk(sx20(mix_r) == er, "R1 R2 R3 R4 R5", {tag, " right mix"}, sx20(mix_r), er);
            @(negedge clk);
            cyc = 1;
        end
        exp_ready = 1'b1;
        stray = 1'b0;
        for (int c = 0; c < 2 * NP; c++) begin
            if (sample_valid === 1'b1 || load_ready !== 1'b1) stray = 1'b1;
            @(negedge clk);
        end
        chk(!stray, "R7", {tag, " idle after frame"}, stray, 0);
    endtask

    function automatic longint envw(input longint a, input longint d);
        return ((a & 64'hFFFF) << 8) | (d & 64'hFF);
    endfunction

    initial begin
        real om, ph;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8
        chk(load_ready == 1'b1, "R8", "reset window", load_ready, 1);
        chk(sample_valid == 1'b0, "R8", "reset valid", sample_valid, 0);
        chk(mix_l == 20'd0 && mix_r == 20'd0, "R8", "reset mix", sx20(mix_l), 0);

        // distinct frequencies, phases and envelopes per partial
        for (int p = 0; p < NP; p++) begin
            om = 0.3 * (p + 1);
            ph = 0.5 * p;
            load_word(2, p, longint'($rtoi(2.0 * $cos(om) * 4194304.0)));
            load_word(1, p, longint'($rtoi(0.9 * $cos(ph) * 8388608.0)));
            load_word(0, p, longint'($rtoi(0.9 * $cos(ph - om) * 8388608.0)));
            load_word(3, p, envw(20000 + p * 9000, 37 - p * 40));
            load_word(4, p, envw(45000 - p * 12000, -20 + p * 25));
        end
        run_frame(1'b0, "frame1");

        // R9: no reload, state continues; R6/R7 stray write and start injected
        run_frame(1'b1, "frame2 R9 R6");

        // R6: unknown code and out-of-range index ignored, env-only update applied
        load_word(5, 0, 24'h000000);
        load_word(7, 1, 24'h7FFFFF);
        load_word(1, 3, 24'h400000);
        load_word(3, 0, envw(65500, 100));   // R3 upper clamp
        load_word(4, 1, envw(60, -100));      // R3 lower clamp
        run_frame(1'b0, "frame3 R3 R6");

        // R5: saturation at both ends of the 20-bit range
        for (int p = 0; p < NP; p++) begin
            load_word(0, p, 24'h7FFFFF);
            load_word(1, p, 24'h7FFFFF);
            load_word(2, p, 24'h000000);
            load_word(3, p, envw(65535, 0));
            load_word(4, p, envw(65535, 0));
        end
        run_frame(1'b0, "frame4 sat");
        chk(first_l == 524287, "R5", "positive saturation left", first_l, 524287);
        chk(first_r == 524287, "R5", "positive saturation right", first_r, 524287);
        for (int p = 0; p < NP; p++) begin
            load_word(0, p, 24'h800000);
            load_word(1, p, 24'h800000);
        end
        run_frame(1'b0, "frame5 sat");
        chk(first_l == -524288, "R5", "negative saturation left", first_l, -524288);
        chk(first_r == -524288, "R5", "negative saturation right", first_r, -524288);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule